// File: doc/BRIEF.md
# I2C Byte-Memory Target with Write-Burst Caps

This block is the serial target side of a 1024-byte memory reached over a two-wire I2C bus. SCL and SDA are sampled by the system clock through two-flop synchronizers. The block finds START and STOP conditions on the sampled lines. It answers one device address and drives SDA through a registered open-drain enable. Writes go into an on-chip byte array. Reads stream bytes out of that array for as long as the controller keeps acknowledging.

A write transfer carries the device byte, then one word-address byte, then data bytes. The two upper address bits travel inside the device byte. The number of data bytes stored in one transfer is capped. The cap is 7 in linear mode and 8 in page mode, and any bytes beyond it are refused. A read uses a repeated START after the word address has been set. The `page_mode` input is captured at each START and selects the cap and the address stepping for that transfer.

Top module: `i2c_mem_target`

## Requirements
- R1: SDA falling while SCL is high (START) returns the block to device-address reception from any state, including mid-transfer. SDA rising while SCL is high (STOP) returns it to idle with `sda_oe` low.
- R2: The device byte is matched as bits[7:4]=1010 and bit3=0, with bits[2:1]=A9:A8 and bit0 the direction (1 = read). On a match the block drives SDA low during the ninth clock. On a mismatch it gives no acknowledge and ignores all bytes until the next START, with memory unchanged.
- R3: In a write, the byte after the device byte sets A7:A0. Each following data byte is acknowledged (SDA low on the ninth clock) and stored at the current address.
- R4: With `page_mode`=0 at START, at most 7 data bytes are stored. The 8th and later bytes get no acknowledge and are not stored. The address steps through the full 10-bit space (0x3FF is followed by 0x000).
- R5: With `page_mode`=1 at START, at most 8 data bytes are stored. The 9th and later bytes get no acknowledge and are not stored. The address steps within its aligned 8-byte page (A2:A0 wrap, A9:A3 held).
- R6: A read sends bytes MSB first from address {A9:A8 of the device byte, A7:A0 of the current pointer}. The pointer advances by one after each byte, through the full 10-bit space with wrap. There is no limit on the number of bytes read.
- R7: When the controller leaves SDA high on the ninth clock of a read byte, the block stops sending and drives nothing until the next START.
- R8: A write of device byte plus word address, followed by a repeated START and a read device byte, reads from the address just written.
- R9: After reset `sda_oe` is low. `sda_oe` only changes while the sampled SCL is low, except when it is released at START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| page_mode | input | 1 | 1 selects the 8-byte page cap and page-wrapped stepping; captured at START |
| sda_oe | output | 1 | Registered open-drain enable; 1 pulls SDA low |

## Verification
The bench uses the default parameters: a 10-bit address space, linear cap 7, page cap 8 and device identifier 1010 with bit3 clear. With these values, write bursts can hit both caps and the page wrap at A2:A0. Reads can cross from 0x3FF to 0x000, and the upper address bits are reached through the device byte. A bench model of the memory tracks only the bytes that are acknowledged. So each readback shows both the stored bytes and the locations the refused bytes must leave untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_WADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } i2cm_state_t;
endpackage

// File: rtl/i2cm_line_mon.sv
// Synchronizes the bus lines and flags clock edges and bus conditions.
module i2cm_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cm_ram.sv
// Byte array with one write port and a registered read port.
module i2cm_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2cm_pkg::*;
#(
  parameter int         AW       = 10,
  parameter logic [6:0] DEV_ADDR = 7'b1010000,
  parameter int         NORM_CAP = 7,
  parameter int         PAGE_CAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic page_mode,
  output logic sda_oe
);
  localparam int HI   = AW - 8;
  localparam int PG   = $clog2(PAGE_CAP);
  localparam int MAXC = (PAGE_CAP > NORM_CAP) ? PAGE_CAP : NORM_CAP;
  localparam int CW   = $clog2(MAXC + 1);

  logic scl_s, sda_s, scl_r, scl_f, start_d, stop_d;

  i2cm_line_mon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_r), .scl_fall(scl_f),
    .start_det(start_d), .stop_det(stop_d)
  );

  i2cm_state_t   state;
  logic [3:0]    cnt;
  logic [7:0]    shreg;
  logic [6:0]    tx;
  logic [AW-1:0] ptr, dev_ptr, next_w, wadr;
  logic [CW-1:0] wcnt, cap;
  logic [7:0]    wdat, rdata;
  logic          mode_q, rw_q, mack, we, tx_load, dev_match;

  i2cm_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(we), .waddr(wadr), .wdata(wdat), .raddr(ptr), .rdata(rdata)
  );

  always_comb begin
    dev_ptr = ptr;
    for (int i = 0; i < HI; i++) dev_ptr[8+i] = shreg[1+i];
    next_w = ptr + AW'(1);
    if (mode_q) next_w = {ptr[AW-1:PG], ptr[PG-1:0] + 1'b1};
  end

  assign dev_match = (shreg[7:HI+1] == DEV_ADDR[6:HI]);
  assign cap       = mode_q ? CW'(PAGE_CAP) : CW'(NORM_CAP);
  assign tx_load   = scl_f && !start_d && !stop_d &&
                     ((state == ST_DACK && rw_q) || (state == ST_RACK && mack));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      cnt    <= 4'd0;
      shreg  <= 8'd0;
      tx     <= 7'd0;
      ptr    <= '0;
      wcnt   <= '0;
      mode_q <= 1'b0;
      rw_q   <= 1'b0;
      mack   <= 1'b0;
      we     <= 1'b0;
      wadr   <= '0;
      wdat   <= 8'd0;
    end else begin
      we <= 1'b0;
      if (start_d) begin
        state  <= ST_DEV;
        sda_oe <= 1'b0;
        cnt    <= 4'd0;
        wcnt   <= '0;
        mode_q <= page_mode;
      end else if (stop_d) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (tx_load) begin
        tx     <= rdata[6:0];
        sda_oe <= ~rdata[7];
        ptr    <= ptr + AW'(1);
        cnt    <= 4'd0;
        state  <= ST_RDATA;
      end else begin
        case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_r) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_f && cnt == 4'd8) begin
              cnt <= 4'd0;
              if (state == ST_DEV) begin
                if (dev_match) begin
                  sda_oe <= 1'b1;
                  rw_q   <= shreg[0];
                  ptr    <= dev_ptr;
                  state  <= ST_DACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_WADDR) begin
                ptr[7:0] <= shreg;
                sda_oe   <= 1'b1;
                state    <= ST_AACK;
              end else begin
                if (wcnt < cap) begin
                  we     <= 1'b1;
                  wadr   <= ptr;
                  wdat   <= shreg;
                  wcnt   <= wcnt + CW'(1);
                  ptr    <= next_w;
                  sda_oe <= 1'b1;
                end
                state <= ST_WACK;
              end
            end
          end
          ST_DACK, ST_AACK, ST_WACK: begin
            if (scl_f) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd0;
              state  <= (state == ST_DACK) ? ST_WADDR : ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_f) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                cnt    <= 4'd0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[5:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_r) mack <= ~sda_s;
            else if (scl_f) state <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the output enable moves only while SCL is low, unless released by START/STOP
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_d) && !$past(stop_d)) |-> !$past(scl_s));

  // R1: a STOP leaves the line released
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
    $past(stop_d) |-> !sda_oe);

  // R2 / R7: while ignoring the bus the block never pulls SDA
  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);

  // R4: no store once the per-transfer cap is reached
  assert_write_cap_R4: assert property (@(posedge clk) disable iff (rst)
    we |-> (wcnt <= cap) && (wcnt != '0));

  // R5: page-mode stepping keeps the upper address bits
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (we && mode_q) |-> ptr[AW-1:PG] == wadr[AW-1:PG]);

  // R6: each byte sent moves the pointer on by one
  assert_read_step_R6: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> ptr == $past(ptr) + AW'(1));
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1, page_mode = 1'b0;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  i2c_mem_target uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .page_mode(page_mode), .sda_oe(sda_oe)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [1024];
  bit         vld   [1024];

  typedef struct packed {
    logic       pm;
    logic [9:0] a;
    logic [4:0] n;
    logic [9:0] ra;
    logic [4:0] rn;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 10'h005, 5'd3,  10'h005, 5'd3, 8'h11},
    '{1'b0, 10'h3FE, 5'd7,  10'h3FE, 5'd7, 8'h40},
    '{1'b0, 10'h100, 5'd9,  10'h100, 5'd9, 8'h62},
    '{1'b1, 10'h21D, 5'd8,  10'h218, 5'd8, 8'h83},
    '{1'b1, 10'h040, 5'd10, 10'h040, 5'd8, 8'hC4}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_sda = b; q(); m_scl = 1'b1; q(); r = sda_line; q(); m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
    end
    clock_bit(~mack, r);
  endtask

  function automatic logic [7:0] dev_byte(input logic [1:0] hi, input logic rd);
    return {4'hA, 1'b0, hi, rd};
  endfunction

  task automatic do_write(input logic pm, input logic [9:0] a, input int n, input logic [7:0] seed);
    logic ack;
    logic [9:0] p;
    int cap;
    cap = pm ? 8 : 7;
    page_mode = pm;
    p = a;
    bus_start();
    send_byte(dev_byte(a[9:8], 1'b0), ack);
    chk("R2", "write device ack", ack, 1);
    send_byte(a[7:0], ack);
    chk("R3", "word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 7);
      send_byte(d, ack);
      if (i >= cap) chk(pm ? "R5" : "R4", "ack beyond cap", ack, 0);
      else          chk(pm ? "R5" : "R3", "data ack within cap", ack, 1);
      if (i < cap) begin
        model[p] = d;
        vld[p]   = 1'b1;
        p = pm ? {p[9:3], p[2:0] + 3'd1} : p + 10'd1;
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [9:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    logic [9:0] p;
    p = a;
    bus_start();
    send_byte(dev_byte(a[9:8], 1'b0), ack);
    chk("R8", "read setup device ack", ack, 1);
    send_byte(a[7:0], ack);
    chk("R8", "read setup address ack", ack, 1);
    bus_start();
    send_byte(dev_byte(a[9:8], 1'b1), ack);
    chk("R8", "read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      if (vld[p]) chk(req, $sformatf("read byte @%0h", p), d, model[p]);
      p = p + 10'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) vld[i] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "sda_oe during reset", sda_oe, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "sda_oe after reset", sda_oe, 0);

    // known bytes where the refused bytes of vector 2 would land (R4)
    do_write(1'b0, 10'h107, 2, 8'hA5);

    for (int v = 0; v < 5; v++) begin
      do_write(VECS[v].pm, VECS[v].a, int'(VECS[v].n), VECS[v].seed);
      do_read(VECS[v].ra, int'(VECS[v].rn), VECS[v].pm ? "R5" : "R6");
    end

    // R2: wrong upper nibble -> no ack, later bytes ignored
    page_mode = 1'b0;
    bus_start();
    send_byte(8'hB0, ack);
    chk("R2", "wrong id ack", ack, 0);
    send_byte(8'h05, ack);
    chk("R2", "ignored address ack", ack, 0);
    send_byte(8'hEE, ack);
    chk("R2", "ignored data ack", ack, 0);
    bus_stop();
    do_read(10'h005, 1, "R2");

    // R2: bit3 set -> no ack
    bus_start();
    send_byte(8'hA8, ack);
    chk("R2", "bit3 mismatch ack", ack, 0);
    bus_stop();

    // R6: long read past 8 bytes
    do_read(10'h100, 12, "R6");

    // R7: controller NACK ends the read; block stays quiet
    bus_start();
    send_byte(dev_byte(2'd0, 1'b0), ack);
    send_byte(8'h05, ack);
    bus_start();
    send_byte(dev_byte(2'd0, 1'b1), ack);
    recv_byte(1'b0, d);
    chk("R7", "single read byte", d, model[10'h005]);
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, r);
      chk("R7", "line released after nack", r, 1);
    end
    bus_stop();
    chk("R1", "sda_oe after stop", sda_oe, 0);

    // R1 / R8: START in the middle of a write restarts address reception
    bus_start();
    send_byte(dev_byte(2'd0, 1'b0), ack);
    send_byte(8'h50, ack);
    send_byte(8'h77, ack);
    chk("R3", "mid-write data ack", ack, 1);
    model[10'h050] = 8'h77;
    vld[10'h050]   = 1'b1;
    bus_start();
    send_byte(dev_byte(2'd0, 1'b0), ack);
    chk("R1", "device ack after restart", ack, 1);
    send_byte(8'h50, ack);
    bus_start();
    send_byte(dev_byte(2'd0, 1'b1), ack);
    chk("R8", "repeated-start read ack", ack, 1);
    recv_byte(1'b0, d);
    chk("R8", "repeated-start read data", d, 8'h77);
    bus_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule